// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block carries out one of sixteen 32-bit data-processing operations each cycle. The operations are arithmetic, logical, move, and compare or test. The first operand comes from the register file. The second operand arrives already shifted from an external shifter, together with that shifter's carry-out. A combinational path produces the result, a result-write enable and the next value of the four status flags. The block holds the flags in its own register and loads that next value on every clock edge. The flags are Negative, Zero, Carry and Overflow.

Each class of operation has its own flag policy. Arithmetic operations update all four flags, and only on request. Logical and move operations update N, Z and C on request and keep V. Compare operations always update all four flags. Test operations always update N, Z and C. Neither compare nor test writes a result. To idle the block, the caller issues any result-writing operation with the set-flags request low; the flags then stay as they are.

Top module: `dp_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `flags_q` becomes 4'b0000 after that edge.
- R2: Opcode encoding (4 bits): AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The logical results are: AND a&b, EOR a^b, ORR a|b, MOV b, BIC a&~b, MVN ~b (bitwise inverse, not negation).
- R3: The arithmetic results, modulo 2^32, with C the current carry flag, are: ADD a+b; ADC a+b+C; SUB a-b; SBC a-b-(1-C); RSB b-a; RSC b-a-(1-C).
- R4: `wr_en` is 0 for opcodes 8 to 11 and 1 for all other opcodes.
- R5: For opcodes 2 to 7 with `set_flags` high, `flags_nx` is computed as follows. N is bit 31 of the result. Z is 1 when the result is zero. C is the unsigned carry out for additions, and for subtractions C is NOT borrow (C=1 when no borrow occurs). V is 1 on two's-complement signed overflow.
- R6: For opcodes 0, 1 and 12 to 15 with `set_flags` high, N and Z follow the result, C takes the value of `shift_c`, and V keeps its current value.
- R7: For opcodes 0 to 7 and 12 to 15 with `set_flags` low, `flags_nx` equals `flags_q`, so the flags hold.
- R8: CMP (a-b) and CMN (a+b) update N, Z, C and V as R5 specifies, whatever the value of `set_flags`.
- R9: TST (a&b) and TEQ (a^b) set N and Z from their value and C from `shift_c`, and keep V, whatever the value of `set_flags`.
- R10: At every rising edge with `rst_n` high, `flags_q` loads `flags_nx`. Both buses use the bit order N=3, Z=2, C=1, V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, already shifted |
| shift_c | input | 1 | Carry-out of the external shifter |
| set_flags | input | 1 | Request to update the flags |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result-write enable |
| flags_nx | output | 4 | Next flag value {N,Z,C,V} |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The assertions run on every cycle and cover the rules that need no operand arithmetic. These are the write enable per opcode class, flags holding when no update is requested, and V being kept by logical and test operations. They also cover N and Z tracking a written result, the register following the next-flag bus, and the reset value. The bench scenarios are what show that each arithmetic value and each carry and overflow flag is correct. That includes carry-in folding for ADC, SBC and RSC, the borrow convention, the reversed operand order, and the shifter carry reaching C. The bench compares these against a wide-integer reference model over directed corner cases and random operand streams.

// File: rtl/dpalu_pkg.sv
// Package: opcode encoding, operation classes and flag bit positions
// shared by the data-processing ALU and its checker.
package dpalu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,   // result-writing, NZC on request, V kept
        CLS_ARITH = 2'd1,   // result-writing, NZCV on request
        CLS_TEST  = 2'd2,   // no write, NZC always, V kept
        CLS_CMP   = 2'd3    // no write, NZCV always
    } dp_class_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int NFLAGS = 4;

    // Map an opcode onto its flag-policy class.
    function automatic dp_class_e op_class(input logic [3:0] op);
        if (op inside {[4'd2:4'd7]})       return CLS_ARITH;
        else if (op inside {4'd8, 4'd9})   return CLS_TEST;
        else if (op inside {4'd10, 4'd11}) return CLS_CMP;
        else                               return CLS_LOGIC;
    endfunction

endpackage

// File: rtl/dpalu_adder.sv
// Adder with optional inversion of either input and a carry-in.
// Subtraction is formed as x + ~y + cin. Assumes the caller selects
// the inversion and carry-in per opcode. Signed overflow is judged on
// the inputs after inversion.
module dpalu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_a,
    input  logic         inv_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] x, y;

    // Conditional operand inversion, then a W+1 bit sum.
    always_comb begin
        x = inv_a ? ~a : a;
        y = inv_b ? ~b : b;
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/dpalu_logic.sv
// Bitwise unit covering the logical, move and test opcodes. For
// arithmetic opcodes it outputs zero; the top ignores it then.
module dpalu_logic
    import dpalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Select the bitwise function from the opcode.
    always_comb begin
        unique case (dp_op_e'(op))
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/dpalu_flagctl.sv
// Flag policy. It chooses which flags take new values for the given
// opcode class and set-flags request, and drives the write enable.
// Assumes val is the value the flags describe (adder sum or logic
// output).
module dpalu_flagctl
    import dpalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]        op,
    input  logic              set_flags,
    input  logic [W-1:0]      val,
    input  logic              add_c,
    input  logic              add_v,
    input  logic              shift_c,
    input  logic [NFLAGS-1:0] cur,
    output logic [NFLAGS-1:0] nxt,
    output logic              wr_en
);
    dp_class_e cls;
    logic      upd_nzc, upd_v, arith;

    // Decide which flags update this cycle.
    always_comb begin
        cls     = op_class(op);
        arith   = (cls == CLS_ARITH) || (cls == CLS_CMP);
        wr_en   = (cls == CLS_ARITH) || (cls == CLS_LOGIC);
        upd_nzc = set_flags || !wr_en;
        upd_v   = arith && upd_nzc;
    end

    // Form the next flag vector, keeping the flags that do not update.
    always_comb begin
        nxt = cur;
        if (upd_nzc) begin
            nxt[FLAG_N] = val[W-1];
            nxt[FLAG_Z] = (val == '0);
            nxt[FLAG_C] = arith ? add_c : shift_c;
        end
        if (upd_v) nxt[FLAG_V] = add_v;
    end
endmodule

// File: rtl/dp_alu.sv
// Top level of the flag-setting data-processing ALU. The datapath is
// combinational and the N/Z/C/V flags are registered. The second
// operand arrives already shifted. Flags load at every clock edge;
// when no update applies they load their own value.
module dp_alu
    import dpalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              shift_c,
    input  logic              set_flags,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic [NFLAGS-1:0] flags_nx,
    output logic [NFLAGS-1:0] flags_q
);
    logic [W-1:0] sum, lval, val;
    logic         inv_a, inv_b, cin, add_c, add_v;

    // Adder setup per opcode: operand inversion and carry-in.
    always_comb begin
        inv_a = 1'b0;
        inv_b = 1'b0;
        cin   = 1'b0;
        unique case (dp_op_e'(op))
            OP_SUB, OP_CMP: begin inv_b = 1'b1; cin = 1'b1; end
            OP_SBC:         begin inv_b = 1'b1; cin = flags_q[FLAG_C]; end
            OP_RSB:         begin inv_a = 1'b1; cin = 1'b1; end
            OP_RSC:         begin inv_a = 1'b1; cin = flags_q[FLAG_C]; end
            OP_ADC:         cin = flags_q[FLAG_C];
            default:        ;
        endcase
    end

    dpalu_adder #(.W(W)) u_add (
        .a(opa), .b(opb), .inv_a(inv_a), .inv_b(inv_b), .cin(cin),
        .sum(sum), .cout(add_c), .ovf(add_v)
    );

    dpalu_logic #(.W(W)) u_log (
        .op(op), .a(opa), .b(opb), .y(lval)
    );

    // Pick the adder or the bitwise value by opcode class.
    always_comb begin
        val    = (op_class(op) inside {CLS_ARITH, CLS_CMP}) ? sum : lval;
        result = val;
    end

    dpalu_flagctl #(.W(W)) u_flg (
        .op(op), .set_flags(set_flags), .val(val), .add_c(add_c),
        .add_v(add_v), .shift_c(shift_c), .cur(flags_q),
        .nxt(flags_nx), .wr_en(wr_en)
    );

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nx;
    end
endmodule

// File: rtl/dp_alu_chk.sv
// Checker for dp_alu: the flag policy and register rules that can be
// observed cycle by cycle at the ports. Attached by the bind below.
module dp_alu_chk
    import dpalu_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op,
    input logic              set_flags,
    input logic [W-1:0]      result,
    input logic              wr_en,
    input logic [NFLAGS-1:0] flags_nx,
    input logic [NFLAGS-1:0] flags_q
);
    logic nowrite_op, logic_op;
    assign nowrite_op = (op >= 4'd8) && (op <= 4'd11);
    assign logic_op   = (op <= 4'd1) || (op >= 4'd12) || (op == 4'd8) || (op == 4'd9);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> flags_q == '0); // R1
    AST_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en == !nowrite_op); // R4
    AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags && !nowrite_op) |=> $stable(flags_q)); // R7
    AST_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        logic_op |=> flags_q[FLAG_V] == $past(flags_q[FLAG_V])); // R6
    AST_NZ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && wr_en) |-> (flags_nx[FLAG_Z] == (result == '0))
                                  && (flags_nx[FLAG_N] == result[W-1])); // R5
    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> flags_q == $past(flags_nx)); // R10
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .set_flags(set_flags),
    .result(result), .wr_en(wr_en), .flags_nx(flags_nx), .flags_q(flags_q)
);

// File: tb/tb_dp_alu.sv
// Self-checking bench: directed corner cases plus seeded random operations
// compared against a wide-integer reference model.
module tb_dp_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd13;
    logic [31:0] opa = '0, opb = '0;
    logic        shift_c = 1'b0, set_flags = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags_nx, flags_q;

    int checks = 0, errors = 0;
    logic [3:0] exp_flags = '0;
    bit done = 0;

    always #5 clk = ~clk;

    dp_alu dut (.clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
        .shift_c(shift_c), .set_flags(set_flags), .result(result),
        .wr_en(wr_en), .flags_nx(flags_nx), .flags_q(flags_q));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, op, act, exp);
        end
    endtask

    // Reference model built from the requirement formulas. Flags are {N,Z,C,V}.
    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic s, input logic [3:0] cf,
                         output logic [31:0] r, output logic w, output logic [3:0] f);
        longint ua, ub, sa, sb, u, sv, bi;
        logic arith, upd;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        bi = cf[1] ? 0 : 1;
        arith = 1; u = 0; sv = 0;
        case (o)
            4'd4, 4'd11: begin u = ua + ub;           sv = sa + sb; end
            4'd5:        begin u = ua + ub + 1 - bi;  sv = sa + sb + 1 - bi; end
            4'd2, 4'd10: begin u = ua - ub;           sv = sa - sb; end
            4'd6:        begin u = ua - ub - bi;      sv = sa - sb - bi; end
            4'd3:        begin u = ub - ua;           sv = sb - sa; end
            4'd7:        begin u = ub - ua - bi;      sv = sb - sa - bi; end
            default:     arith = 0;
        endcase
        case (o)
            4'd0, 4'd8:  r = a & b;
            4'd1, 4'd9:  r = a ^ b;
            4'd12:       r = a | b;
            4'd13:       r = b;
            4'd14:       r = a & ~b;
            4'd15:       r = ~b;
            default:     r = u[31:0];
        endcase
        w = !(o >= 4'd8 && o <= 4'd11);
        upd = s || !w;
        f = cf;
        if (upd) begin
            f[3] = r[31];
            f[2] = (r == 0);
            if (arith) begin
                if (o inside {4'd4, 4'd5, 4'd11}) f[1] = (u >= 64'sh1_0000_0000);
                else                              f[1] = (u >= 0);
                f[0] = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
            end else begin
                f[1] = sc;
            end
        end
    endtask

    function automatic string rtag(input logic [3:0] o);
        return (o >= 4'd2 && o <= 4'd7) ? "R3" : "R2";
    endfunction

    function automatic string ftag(input logic [3:0] o, input logic s);
        if (o == 4'd10 || o == 4'd11) return "R8";
        if (o == 4'd8 || o == 4'd9)   return "R9";
        if (!s)                       return "R7";
        return (o >= 4'd2 && o <= 4'd7) ? "R5" : "R6";
    endfunction

    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic s);
        logic [31:0] r; logic w; logic [3:0] f;
        @(negedge clk);
        op = o; opa = a; opb = b; shift_c = sc; set_flags = s;
        #1;
        model(o, a, b, sc, s, exp_flags, r, w, f);
        if (w) chk(rtag(o), result, r);
        chk("R4", {31'b0, wr_en}, {31'b0, w});
        chk(ftag(o, s), {28'b0, flags_nx}, {28'b0, f});
        @(posedge clk); #1;
        exp_flags = f;
        chk("R10", {28'b0, flags_q}, {28'b0, f});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {28'b0, flags_q}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        // Arithmetic corners
        run(4'd4, 32'h7fff_ffff, 32'h1, 1'b0, 1'b1);       // R5 signed overflow, V=1
        run(4'd8, 32'hf0f0_0000, 32'h0f0f_0000, 1'b1, 1'b0); // R9 Z=1, C=shift, V kept
        run(4'd13, 32'h0, 32'h0, 1'b0, 1'b1);              // R6 MOV 0, V kept
        run(4'd2, 32'h0, 32'h1, 1'b0, 1'b1);               // R5 borrow -> C=0
        run(4'd5, 32'hffff_ffff, 32'h0, 1'b0, 1'b1);       // R3 ADC with C=0
        run(4'd2, 32'h5, 32'h5, 1'b0, 1'b1);               // R5 equal -> Z=1,C=1
        run(4'd5, 32'hffff_ffff, 32'h0, 1'b0, 1'b1);       // R3 ADC with C=1 -> carry
        run(4'd7, 32'h3, 32'h10, 1'b0, 1'b1);              // R3 RSC with C=1
        run(4'd6, 32'h8000_0000, 32'h1, 1'b0, 1'b1);       // R3 SBC signed overflow
        run(4'd10, 32'h1, 32'h2, 1'b0, 1'b0);              // R8 CMP with S low
        run(4'd11, 32'hffff_ffff, 32'h1, 1'b0, 1'b0);      // R8 CMN with S low
        run(4'd15, 32'h0, 32'h1234_5678, 1'b1, 1'b1);      // R2 MVN bitwise not
        run(4'd14, 32'hffff_ffff, 32'h0000_ffff, 1'b0, 1'b1); // R2 BIC
        run(4'd3, 32'h10, 32'h4, 1'b0, 1'b0);              // R7 RSB, flags hold
        run(4'd9, 32'haaaa_aaaa, 32'haaaa_aaaa, 1'b0, 1'b0); // R9 TEQ
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if ($urandom_range(0, 7) == 0) rb = ra;
            if ($urandom_range(0, 7) == 0) ra = 32'h8000_0000;
            run(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 1'($urandom));
        end
        // Reset in the middle clears flags
        run(4'd10, 32'h0, 32'h0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", {28'b0, flags_q}, 32'd0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule